// File: doc/BRIEF.md
# Five-Locality Ownership Arbiter

This block decides which of five requesters, numbered 0 to 4, owns a shared security device at any moment. Each requester reaches the block through an already decoded write strobe tagged with its number and carrying a four-bit command: ask for ownership, give it up, take it by force, or set the established flag. The block answers through a per-requester view of "granted" and "was seized" and through one 8-bit state word. That word carries the current owner's number, an assigned flag, the established flag and a valid flag.

Arbitration is by number: a larger number always wins. Requests made while another requester owns the device wait as pending bits. When the device is free, the largest pending number takes it. A requester with a larger number than the current owner may seize the device at once. The displaced owner is left with a sticky "was seized" flag. The established flag starts at 1. Only requesters 3 and 4 can set it again, and a dedicated hash-end input clears it.

Top module: `loc_owner_arb`

## Requirements
- R1: While reset is asserted the state word reads 8'h01, and it reads 8'h81 from the first clock edge after reset is released. granted and seized read all zero: nobody owns the device and the established flag is 1.
- R2: State word layout is {valid, 2'b00, activeLoc[2:0], assigned, established}. activeLoc is in bits 4:2, assigned in bit 1, established in bit 0 and valid in bit 7. activeLoc reads 000 whenever no requester owns the device. At most one granted bit is 1.
- R3: A request write (command bit 0) arriving while no requester owns the device grants ownership at the same clock edge to the largest number among the writer and the pending requesters.
- R4: When the device becomes free with requests pending, the state word shows assigned=0 for one cycle. The largest pending number is then granted at the next edge, and its pending bit is consumed.
- R5: A relinquish write (command bit 1) from the owner frees the device at that edge. A relinquish from a non-owner has no effect.
- R6: A seize write (command bit 2) from a number larger than the owner's makes the writer owner at that edge. The previous owner then reads seized=1 and granted=0, and it is not queued again.
- R7: A seize from a number equal to or smaller than the owner's, or sent while no one owns the device, has no effect.
- R8: A requester's seized flag stays 1 until that requester sends a request write, which clears it.
- R9: A reset-establishment write (command bit 3) sets the established flag only when it comes from requester 3 or 4. It has no effect from requesters 0 to 2.
- R10: A pulse on hashEnd clears the established flag at the next edge. If a valid set arrives in the same cycle, the set wins.
- R11: A request write from the current owner is not queued: after that owner relinquishes, it is not granted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe |
| wrLoc | input | 3 | Number of the writing requester; values above 4 are ignored |
| wrCmd | input | 4 | Command bits: 0 request, 1 relinquish, 2 seize, 3 set established |
| hashEnd | input | 1 | One-cycle pulse that clears the established flag |
| grantedVec | output | 5 | Bit i is 1 when requester i owns the device |
| seizedVec | output | 5 | Bit i is the sticky seized flag of requester i |
| stateWord | output | 8 | Global state word (layout in R2) |

## Verification
The hardest case to reach is the choice among several pending requesters at the moment the device becomes free. Every request must arrive while some other requester still holds the device, and the order of release then decides who is next. The stimulus grants requester 1 first and queues 0, 2 and 3 behind it; requester 1 also issues a redundant request of its own. The owners are then released one by one, and the bench watches the one-cycle unassigned gap and each grant that follows. The seized flag needs a second constructed situation: an owner displaced by a larger number, then left idle for several cycles before it requests again.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_IDX_W = 3;

  typedef struct packed {
    logic                 grantEn;
    logic [LOC_IDX_W-1:0] grantLoc;
    logic                 releaseEn;
    logic                 seizeEn;
    logic [LOC_IDX_W-1:0] seizeLoc;
    logic                 pendSet;
    logic                 seizedClr;
    logic [LOC_IDX_W-1:0] pendLoc;
    logic                 estSet;
    logic                 estClr;
  } arbStrobes_t;
endpackage

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic                 wrEn,
  input  logic [LOC_IDX_W-1:0] wrLoc,
  input  logic [3:0]           wrCmd,
  input  logic                 hashEnd,
  input  logic                 ownerValid,
  input  logic [LOC_IDX_W-1:0] ownerLoc,
  input  logic [NUM_LOC-1:0]   pendVec,
  output arbStrobes_t          strobes
);
  localparam logic [LOC_IDX_W-1:0] LAST_LOC = LOC_IDX_W'(NUM_LOC - 1);
  localparam logic [LOC_IDX_W-1:0] EST_MIN_LOC = LOC_IDX_W'(3);

  logic locOk;
  logic isOwner;
  logic [NUM_LOC-1:0] candVec;

  always_comb begin
    locOk   = wrEn && (wrLoc <= LAST_LOC);
    isOwner = ownerValid && (ownerLoc == wrLoc);

    strobes           = '0;
    strobes.seizeLoc  = wrLoc;
    strobes.pendLoc   = wrLoc;
    strobes.seizeEn   = locOk && wrCmd[2] && ownerValid && (wrLoc > ownerLoc);
    strobes.releaseEn = locOk && wrCmd[1] && isOwner;
    strobes.pendSet   = locOk && wrCmd[0] && !isOwner;
    strobes.seizedClr = locOk && wrCmd[0];
    strobes.estSet    = locOk && wrCmd[3] && (wrLoc >= EST_MIN_LOC);
    strobes.estClr    = hashEnd;

    // free device: the new request joins the pending set in the same edge
    candVec = pendVec | (strobes.pendSet ? (NUM_LOC'(1) << wrLoc) : '0);
    strobes.grantEn = !ownerValid && (|candVec);
    for (int i = 0; i < NUM_LOC; i++) begin
      if (candVec[i]) strobes.grantLoc = LOC_IDX_W'(i);
    end
  end
endmodule

// File: rtl/loc_arb_dp.sv
module loc_arb_dp
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  arbStrobes_t          strobes,
  output logic                 ownerValid,
  output logic [LOC_IDX_W-1:0] ownerLoc,
  output logic [NUM_LOC-1:0]   pendVec,
  output logic [NUM_LOC-1:0]   grantedVec,
  output logic [NUM_LOC-1:0]   seizedVec,
  output logic [7:0]           stateWord
);
  logic                 ownerQ;
  logic [LOC_IDX_W-1:0] ownerLocQ;
  logic [NUM_LOC-1:0]   pendQ, pendNext;
  logic [NUM_LOC-1:0]   seizedQ, seizedNext;
  logic                 estQ;
  logic                 validQ;

  always_comb begin
    pendNext = pendQ;
    if (strobes.pendSet) pendNext[strobes.pendLoc] = 1'b1;
    if (strobes.grantEn) pendNext[strobes.grantLoc] = 1'b0;
    if (strobes.seizeEn) pendNext[strobes.seizeLoc] = 1'b0;

    seizedNext = seizedQ;
    if (strobes.seizedClr) seizedNext[strobes.pendLoc] = 1'b0;
    if (strobes.seizeEn)   seizedNext[ownerLocQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ownerQ    <= 1'b0;
      ownerLocQ <= '0;
      pendQ     <= '0;
      seizedQ   <= '0;
      estQ      <= 1'b1;
      validQ    <= 1'b0;
    end else begin
      validQ  <= 1'b1;
      pendQ   <= pendNext;
      seizedQ <= seizedNext;
      if (strobes.grantEn) begin
        ownerQ    <= 1'b1;
        ownerLocQ <= strobes.grantLoc;
      end else if (strobes.seizeEn) begin
        ownerLocQ <= strobes.seizeLoc;
      end else if (strobes.releaseEn) begin
        ownerQ    <= 1'b0;
        ownerLocQ <= '0;
      end
      if (strobes.estSet)      estQ <= 1'b1;
      else if (strobes.estClr) estQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_grant
    assign grantedVec[i] = ownerQ && (ownerLocQ == LOC_IDX_W'(i));
  end

  assign ownerValid = ownerQ;
  assign ownerLoc   = ownerLocQ;
  assign pendVec    = pendQ;
  assign seizedVec  = seizedQ;
  assign stateWord  = {validQ, 2'b00, ownerLocQ, ownerQ, estQ};

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantedVec));
  p_grant_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.grantEn |-> !ownerQ);
  p_grant_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.grantEn |=> ownerQ && (ownerLocQ == $past(strobes.grantLoc)));
  p_release_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.releaseEn |=> !ownerQ);
  p_seize_higher_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.seizeEn |-> ownerQ && (strobes.seizeLoc > ownerLocQ));
  p_seize_flags_loser_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.seizeEn |=> seizedQ[$past(ownerLocQ)] && (ownerLocQ == $past(strobes.seizeLoc)));
  p_est_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.estSet |=> estQ);
  p_est_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.estClr && !strobes.estSet) |=> !estQ);
endmodule

// File: rtl/loc_owner_arb.sv
module loc_owner_arb
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [LOC_IDX_W-1:0] wrLoc,
  input  logic [3:0]           wrCmd,
  input  logic                 hashEnd,
  output logic [NUM_LOC-1:0]   grantedVec,
  output logic [NUM_LOC-1:0]   seizedVec,
  output logic [7:0]           stateWord
);
  arbStrobes_t          strobes;
  logic                 ownerValid;
  logic [LOC_IDX_W-1:0] ownerLoc;
  logic [NUM_LOC-1:0]   pendVec;

  loc_arb_ctrl #(.NUM_LOC(NUM_LOC)) i_ctrl (
    .wrEn       (wrEn),
    .wrLoc      (wrLoc),
    .wrCmd      (wrCmd),
    .hashEnd    (hashEnd),
    .ownerValid (ownerValid),
    .ownerLoc   (ownerLoc),
    .pendVec    (pendVec),
    .strobes    (strobes)
  );

  loc_arb_dp #(.NUM_LOC(NUM_LOC)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .ownerValid (ownerValid),
    .ownerLoc   (ownerLoc),
    .pendVec    (pendVec),
    .grantedVec (grantedVec),
    .seizedVec  (seizedVec),
    .stateWord  (stateWord)
  );
endmodule

// File: tb/test_loc_owner_arb.sv
module test_loc_owner_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrLoc = '0;
  logic [3:0] wrCmd = '0;
  logic       hashEnd = 1'b0;
  logic [4:0] grantedVec, seizedVec;
  logic [7:0] stateWord;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] C_REQ = 4'b0001, C_REL = 4'b0010,
                         C_SEIZE = 4'b0100, C_EST = 4'b1000;

  always #5 clk = ~clk;

  loc_owner_arb i_loc_owner_arb (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrLoc(wrLoc), .wrCmd(wrCmd),
    .hashEnd(hashEnd), .grantedVec(grantedVec), .seizedVec(seizedVec),
    .stateWord(stateWord)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // owner word: valid | loc<<2 | assigned | est
  function automatic logic [7:0] sw(input bit own, input int loc, input bit est);
    return 8'h80 | (own ? (8'(loc) << 2) | 8'h02 : 8'h00) | (est ? 8'h01 : 8'h00);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doWrite(input int loc, input logic [3:0] cmd);
    @(negedge clk);
    wrEn = 1'b1; wrLoc = 3'(loc); wrCmd = cmd;
    @(negedge clk);
    wrEn = 1'b0; wrCmd = '0;
  endtask

  task automatic pulseHash(input bit withSet, input int loc);
    @(negedge clk);
    hashEnd = 1'b1;
    if (withSet) begin wrEn = 1'b1; wrLoc = 3'(loc); wrCmd = C_EST; end
    @(negedge clk);
    hashEnd = 1'b0; wrEn = 1'b0; wrCmd = '0;
  endtask

  task automatic testReset();
    repeat (3) tick();
    chk("R1", "state in reset", stateWord, 8'h01);
    rst_n = 1'b1;
    tick();
    chk("R1", "state after reset", stateWord, 8'h81);
    chk("R1", "granted after reset", 8'(grantedVec), 8'h00);
    chk("R1", "seized after reset", 8'(seizedVec), 8'h00);
  endtask

  task automatic testQueue();
    doWrite(1, C_REQ);
    chk("R3", "idle request grants", stateWord, sw(1, 1, 1));
    chk("R2", "granted bit 1", 8'(grantedVec), 8'h02);
    doWrite(0, C_REQ);
    doWrite(2, C_REQ);
    doWrite(3, C_REQ);
    doWrite(1, C_REQ);
    chk("R11", "owner kept while others queue", stateWord, sw(1, 1, 1));
    doWrite(0, C_REL);
    chk("R5", "relinquish by non-owner ignored", stateWord, sw(1, 1, 1));
    doWrite(1, C_REL);
    chk("R4", "free gap", stateWord, sw(0, 0, 1));
    tick();
    chk("R4", "highest pending 3 granted", stateWord, sw(1, 3, 1));
    doWrite(3, C_REL);
    chk("R5", "owner 3 released", stateWord, sw(0, 0, 1));
    tick();
    chk("R4", "next pending 2 granted", stateWord, sw(1, 2, 1));
    doWrite(2, C_REL);
    tick();
    chk("R4", "last pending 0 granted", stateWord, sw(1, 0, 1));
    chk("R2", "granted bit 0", 8'(grantedVec), 8'h01);
    doWrite(0, C_REL);
    tick();
    chk("R11", "owner self-request not queued", stateWord, sw(0, 0, 1));
    chk("R2", "no granted bits", 8'(grantedVec), 8'h00);
  endtask

  task automatic testSeize();
    doWrite(1, C_REQ);
    doWrite(0, C_SEIZE);
    chk("R7", "lower seize ignored", stateWord, sw(1, 1, 1));
    doWrite(1, C_SEIZE);
    chk("R7", "equal seize ignored", stateWord, sw(1, 1, 1));
    doWrite(4, C_SEIZE);
    chk("R6", "seize by 4", stateWord, sw(1, 4, 1));
    chk("R6", "granted moves to 4", 8'(grantedVec), 8'h10);
    chk("R6", "loser seized flag", 8'(seizedVec), 8'h02);
    doWrite(3, C_SEIZE);
    chk("R7", "seize by 3 under 4 ignored", stateWord, sw(1, 4, 1));
    doWrite(4, C_REL);
    tick();
    chk("R6", "loser not requeued", stateWord, sw(0, 0, 1));
    doWrite(2, C_SEIZE);
    chk("R7", "seize with no owner ignored", stateWord, sw(0, 0, 1));
    repeat (4) tick();
    chk("R8", "seized flag sticky", 8'(seizedVec), 8'h02);
    doWrite(1, C_REQ);
    chk("R8", "request clears seized", 8'(seizedVec), 8'h00);
    chk("R3", "re-request granted", stateWord, sw(1, 1, 1));
    doWrite(1, C_REL);
  endtask

  task automatic testEstablished();
    pulseHash(1'b0, 0);
    chk("R10", "hash end clears", stateWord, sw(0, 0, 0));
    for (int l = 0; l < 3; l++) begin
      doWrite(l, C_EST);
      chk("R9", $sformatf("set from %0d ignored", l), stateWord, sw(0, 0, 0));
    end
    doWrite(3, C_EST);
    chk("R9", "set from 3", stateWord, sw(0, 0, 1));
    pulseHash(1'b0, 0);
    chk("R10", "cleared again", stateWord, sw(0, 0, 0));
    doWrite(4, C_EST);
    chk("R9", "set from 4", stateWord, sw(0, 0, 1));
    pulseHash(1'b1, 3);
    chk("R10", "set wins over hash end", stateWord, sw(0, 0, 1));
    pulseHash(1'b1, 1);
    chk("R10", "hash end with ignored set", stateWord, sw(0, 0, 0));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testQueue();
    testSeize();
    testEstablished();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule